// File: doc/BRIEF.md
# Global Bus Request-Grant Handshake

This block connects a 16-bit processor to a global RAM that several bus masters share. The processor's address decoder marks a global access by pulling an active-low request. The block then latches the access: the low 16 bits of the processor address, the direction and the write data. It raises an active-low memory request toward the global RAM arbiter and waits for the arbiter's grant. The grant drops the memory request. Only after that does the block assert the active-low global cycle line, which carries the read/write command.

During a write cycle the block enables its drivers onto the global data bus. During a read cycle it latches the global data when the memory side returns its data strobe. The strobe also ends the cycle in both directions. The processor gets a one-cycle acknowledge, and it must hold its request and operands until then. The grant and the strobe come from another clock domain, so each passes through a two-flop synchronizer before the state machine uses it.

The state machine has five states. IDLE waits for work. REQUEST drives the memory request. GRANTED is a single cycle in which neither the request nor the cycle line is asserted. TRANSFER drives the cycle line. DONE pulses the acknowledge. The transitions are:
- IDLE to REQUEST on a processor request, taken only while the synchronized grant and strobe are both released.
- REQUEST to GRANTED on the synchronized grant.
- GRANTED to TRANSFER unconditionally.
- TRANSFER to DONE on the synchronized strobe.
- DONE to IDLE unconditionally.

Top module: `gbus_handshake`

## Requirements
- R1: While reset is asserted, the block shows this state at its outputs: `mem_req_n` = 1, `glb_cycle_n` = 1, `glb_doe` = 0, `cpu_ack` = 0, `glb_write` = 0, `glb_addr` = 0 and `cpu_rdata` = 0.
- R2: In IDLE, when `cpu_greq_n` is 0 at a clock edge and the synchronized grant and strobe are both released, that edge does two things. It latches `cpu_addr[15:0]`, `cpu_we` and `cpu_wdata`, and it enters REQUEST, where `mem_req_n` is 0.
- R3: `mem_req_n` stays 0 until the synchronized grant (`mem_gnt_n` = 0) is seen. It returns to 1 at the edge that enters GRANTED. `mem_req_n` and `glb_cycle_n` are never both 0.
- R4: GRANTED lasts exactly one cycle. `glb_cycle_n` falls at the next edge, so the last cycle before it falls always has `mem_req_n` = 1 and the cycle before that has `mem_req_n` = 0.
- R5: `glb_doe` is 1 only in TRANSFER with a latched write (`glb_write` = 1, meaning write). While it is 1, `glb_dout` carries the latched write data.
- R6: In a read, `cpu_rdata` takes the value of `glb_din` at the edge where the synchronized strobe (`glb_strobe_n` = 0) is first seen in TRANSFER. A write leaves `cpu_rdata` unchanged.
- R7: The synchronized strobe moves TRANSFER to DONE. `cpu_ack` is 1 for exactly that one DONE cycle, and the next edge returns to IDLE.
- R8: A processor request that is still pending after DONE is held off. No new memory request starts until the block is in IDLE and the synchronized grant and strobe are both released.
- R9: The grant and the strobe each cross two synchronizer flops. A level applied before clock edge k is acted on by the state machine at edge k+2.
- R10: `glb_addr` shows the low 16 bits of the latched processor address for the whole access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_greq_n | input | 1 | Global access request from the processor decoder, active low |
| cpu_we | input | 1 | Access direction, 1 = write |
| cpu_addr | input | 24 | Processor address |
| cpu_wdata | input | 16 | Processor write data |
| cpu_rdata | output | 16 | Data captured by the last read |
| cpu_ack | output | 1 | One-cycle completion pulse to the processor |
| mem_req_n | output | 1 | Memory request to the global arbiter, active low |
| mem_gnt_n | input | 1 | Memory grant from the arbiter, active low, asynchronous |
| glb_cycle_n | output | 1 | Global read/write cycle line, active low |
| glb_write | output | 1 | Latched direction, 1 = write |
| glb_addr | output | 16 | Global address |
| glb_dout | output | 16 | Write data toward the global bus |
| glb_doe | output | 1 | Output enable for the global data drivers |
| glb_din | input | 16 | Read data from the global bus |
| glb_strobe_n | input | 1 | Global data strobe, active low, asynchronous |

## Verification
Every output is decoded directly from the state or from registers, so a wrong state shows at the ports in the cycle after the faulty edge:
- A stuck REQUEST keeps `mem_req_n` low past the point where the grant has been synchronized.
- A skipped GRANTED makes `glb_cycle_n` fall right after `mem_req_n` rises.
- A lost DONE removes the acknowledge pulse.

The bench runs a behavioural model of the sequence, with its own two-edge delay for the grant and strobe, and compares every output on every cycle. A one-cycle error in the synchronizer depth or in a transition therefore shows up at the first access that follows. Read-after-write data through a small memory model in the responder covers both capture and drive.

// File: rtl/gbus_hs_pkg.sv
package gbus_hs_pkg;

    typedef enum logic [2:0] {
        ST_IDLE     = 3'd0,
        ST_REQUEST  = 3'd1,
        ST_GRANTED  = 3'd2,
        ST_TRANSFER = 3'd3,
        ST_DONE     = 3'd4
    } hs_state_t;

endpackage

// File: rtl/gbus_sync.sv
module gbus_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= d;
            end
        end else begin : g_multi
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];
endmodule

// File: rtl/gbus_fsm.sv
module gbus_fsm
    import gbus_hs_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      start_req,
    input  logic      gnt_seen,
    input  logic      stb_seen,
    output hs_state_t state,
    output logic      load,
    output logic      capture
);
    hs_state_t state_nx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:     if (start_req && !gnt_seen && !stb_seen) state_nx = ST_REQUEST;
            ST_REQUEST:  if (gnt_seen) state_nx = ST_GRANTED;
            ST_GRANTED:  state_nx = ST_TRANSFER;
            ST_TRANSFER: if (stb_seen) state_nx = ST_DONE;
            ST_DONE:     state_nx = ST_IDLE;
            default:     state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        load    = 1'b0;
        capture = 1'b0;
        unique case (state)
            ST_IDLE:     load    = start_req && !gnt_seen && !stb_seen;
            ST_TRANSFER: capture = stb_seen;
            default: ;
        endcase
    end

    // R8
    idle_entry_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_REQUEST && $past(state) != ST_REQUEST) |->
            ($past(state) == ST_IDLE && !$past(gnt_seen) && !$past(stb_seen)));

    // R7
    done_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_DONE) |=> (state == ST_IDLE));
endmodule

// File: rtl/gbus_datapath.sv
module gbus_datapath #(
    parameter int CPU_AW = 24,
    parameter int GLB_AW = 16,
    parameter int DW     = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              capture,
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic              cpu_we,
    input  logic [DW-1:0]     cpu_wdata,
    input  logic [DW-1:0]     glb_din,
    output logic [GLB_AW-1:0] addr_q,
    output logic              we_q,
    output logic [DW-1:0]     wdata_q,
    output logic [DW-1:0]     rdata_q
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q  <= '0;
            we_q    <= 1'b0;
            wdata_q <= '0;
        end else if (load) begin
            addr_q  <= cpu_addr[GLB_AW-1:0];
            we_q    <= cpu_we;
            wdata_q <= cpu_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                rdata_q <= '0;
        else if (capture && !we_q) rdata_q <= glb_din;
    end

    // R6
    write_keeps_rdata_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(we_q) |-> $stable(rdata_q));
endmodule

// File: rtl/gbus_handshake.sv
module gbus_handshake
    import gbus_hs_pkg::*;
#(
    parameter int CPU_AW      = 24,
    parameter int GLB_AW      = 16,
    parameter int DW          = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_greq_n,
    input  logic              cpu_we,
    input  logic [CPU_AW-1:0] cpu_addr,
    input  logic [DW-1:0]     cpu_wdata,
    output logic [DW-1:0]     cpu_rdata,
    output logic              cpu_ack,
    output logic              mem_req_n,
    input  logic              mem_gnt_n,
    output logic              glb_cycle_n,
    output logic              glb_write,
    output logic [GLB_AW-1:0] glb_addr,
    output logic [DW-1:0]     glb_dout,
    output logic              glb_doe,
    input  logic [DW-1:0]     glb_din,
    input  logic              glb_strobe_n
);
    hs_state_t state;
    logic      gnt_seen, stb_seen, load, capture, we_q;

    gbus_sync #(.STAGES(SYNC_STAGES)) u_gnt_sync (
        .clk(clk), .rst_n(rst_n), .d(~mem_gnt_n), .q(gnt_seen));

    gbus_sync #(.STAGES(SYNC_STAGES)) u_stb_sync (
        .clk(clk), .rst_n(rst_n), .d(~glb_strobe_n), .q(stb_seen));

    gbus_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .start_req(~cpu_greq_n),
        .gnt_seen(gnt_seen), .stb_seen(stb_seen),
        .state(state), .load(load), .capture(capture));

    gbus_datapath #(.CPU_AW(CPU_AW), .GLB_AW(GLB_AW), .DW(DW)) u_dp (
        .clk(clk), .rst_n(rst_n), .load(load), .capture(capture),
        .cpu_addr(cpu_addr), .cpu_we(cpu_we), .cpu_wdata(cpu_wdata),
        .glb_din(glb_din), .addr_q(glb_addr), .we_q(we_q),
        .wdata_q(glb_dout), .rdata_q(cpu_rdata));

    always_comb begin
        mem_req_n   = 1'b1;
        glb_cycle_n = 1'b1;
        glb_doe     = 1'b0;
        cpu_ack     = 1'b0;
        unique case (state)
            ST_REQUEST:  mem_req_n = 1'b0;
            ST_TRANSFER: begin
                glb_cycle_n = 1'b0;
                glb_doe     = we_q;
            end
            ST_DONE:     cpu_ack = 1'b1;
            default: ;
        endcase
    end

    assign glb_write = we_q;

    // R3
    req_cycle_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(!mem_req_n && !glb_cycle_n));

    // R4
    granted_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(glb_cycle_n) |-> ($past(mem_req_n) && !$past(mem_req_n, 2)));

    // R5
    doe_in_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        glb_doe |-> (!glb_cycle_n && glb_write));

    // R7
    ack_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_ack |=> !cpu_ack);

    // R10
    addr_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!glb_cycle_n && !$past(glb_cycle_n)) |-> $stable(glb_addr));
endmodule

// File: tb/gbus_handshake_test.sv
module gbus_handshake_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_greq_n = 1'b1;
    logic        cpu_we = 1'b0;
    logic [23:0] cpu_addr = '0;
    logic [15:0] cpu_wdata = '0;
    logic [15:0] cpu_rdata;
    logic        cpu_ack;
    logic        mem_req_n;
    logic        mem_gnt_n = 1'b1;
    logic        glb_cycle_n;
    logic        glb_write;
    logic [15:0] glb_addr;
    logic [15:0] glb_dout;
    logic        glb_doe;
    logic [15:0] glb_din = '0;
    logic        glb_strobe_n = 1'b1;

    int checks = 0;
    int errors = 0;

    gbus_handshake uut (.*);

    always #10 clk = ~clk;

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", req, what, act, exp, $time);
        end
    endtask

    // behavioural reference: 0 idle, 1 request, 2 granted, 3 transfer, 4 done
    int          m_st = 0;
    bit          gq[$];
    bit          sq[$];
    logic [15:0] m_addr = '0, m_wd = '0, m_rd = '0;
    logic        m_we = 1'b0;
    bit          model_on = 0;

    always @(posedge clk) begin
        bit g_old, s_old;
        if (!rst_n) begin
            m_st = 0; m_addr = '0; m_wd = '0; m_rd = '0; m_we = 1'b0;
            gq = {1'b0, 1'b0}; sq = {1'b0, 1'b0};
        end else begin
            g_old = gq.pop_back();
            s_old = sq.pop_back();
            gq.push_front(!mem_gnt_n);
            sq.push_front(!glb_strobe_n);
            case (m_st)
                0: if (!cpu_greq_n && !g_old && !s_old) begin
                       m_addr = cpu_addr[15:0]; m_we = cpu_we; m_wd = cpu_wdata; m_st = 1;
                   end
                1: if (g_old) m_st = 2;
                2: m_st = 3;
                3: if (s_old) begin
                       if (!m_we) m_rd = glb_din;
                       m_st = 4;
                   end
                default: m_st = 0;
            endcase
        end
    end

    // responder memory and knobs
    logic [15:0] mem [16];
    int gd = 2, sd = 2, rel = 1;
    int gcnt = 0, scnt = 0, rcnt = 0;
    bit gnt_on = 0, saw = 0;

    always @(negedge clk) begin
        if (model_on && rst_n) begin
            chk("R2 R3 R9", "mem_req_n", 32'(mem_req_n), 32'(m_st != 1));
            chk("R4", "glb_cycle_n", 32'(glb_cycle_n), 32'(m_st != 3));
            chk("R5", "glb_doe", 32'(glb_doe), 32'(m_st == 3 && m_we));
            if (glb_doe) chk("R5", "glb_dout", 32'(glb_dout), 32'(m_wd));
            chk("R2", "glb_write", 32'(glb_write), 32'(m_we));
            chk("R10", "glb_addr", 32'(glb_addr), 32'(m_addr));
            chk("R6", "cpu_rdata", 32'(cpu_rdata), 32'(m_rd));
            chk("R7", "cpu_ack", 32'(cpu_ack), 32'(m_st == 4));
        end
        if (rst_n) begin
            if (!gnt_on && !mem_req_n) begin
                gcnt++;
                if (gcnt >= gd) begin mem_gnt_n <= 1'b0; gnt_on = 1; gcnt = 0; end
            end
            if (gnt_on && !glb_cycle_n && glb_strobe_n && !saw) begin
                scnt++;
                if (scnt >= sd) begin
                    glb_strobe_n <= 1'b0;
                    if (glb_doe) mem[glb_addr[3:0]] = glb_dout;
                    else         glb_din <= mem[glb_addr[3:0]];
                    saw = 1; scnt = 0;
                end
            end
            if (saw && glb_cycle_n) begin
                rcnt++;
                if (rcnt >= rel) begin
                    mem_gnt_n <= 1'b1; glb_strobe_n <= 1'b1;
                    gnt_on = 0; saw = 0; rcnt = 0;
                end
            end
        end
    end

    task automatic txn(input bit we, input logic [23:0] a, input logic [15:0] d, input bit keep);
        @(negedge clk);
        cpu_greq_n = 1'b0; cpu_we = we; cpu_addr = a; cpu_wdata = d;
        do @(negedge clk); while (!cpu_ack);
        if (!keep) cpu_greq_n = 1'b1;
    endtask

    initial begin
        for (int i = 0; i < 16; i++) mem[i] = 16'(i * 16'h1111);
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "mem_req_n", 32'(mem_req_n), 32'd1);
        chk("R1", "glb_cycle_n", 32'(glb_cycle_n), 32'd1);
        chk("R1", "glb_doe", 32'(glb_doe), 32'd0);
        chk("R1", "cpu_ack", 32'(cpu_ack), 32'd0);
        chk("R1", "glb_write", 32'(glb_write), 32'd0);
        chk("R1", "glb_addr", 32'(glb_addr), 32'd0);
        chk("R1", "cpu_rdata", 32'(cpu_rdata), 32'd0);
        rst_n = 1'b1;
        model_on = 1;
        repeat (2) @(negedge clk);

        // R10: upper address bits are dropped on the global side
        gd = 1; sd = 1; rel = 1;
        txn(1'b1, 24'hAB_0003, 16'hBEEF, 1'b0);
        repeat (4) @(negedge clk);
        txn(1'b0, 24'h55_0003, 16'h0000, 1'b0);
        chk("R6", "read-after-write data", 32'(cpu_rdata), 32'h0000_BEEF);

        // slower grant and strobe
        gd = 5; sd = 4; rel = 2;
        repeat (4) @(negedge clk);
        txn(1'b1, 24'h00_1237, 16'hA5C3, 1'b0);
        repeat (5) @(negedge clk);
        txn(1'b0, 24'hFF_FFF7, 16'h0000, 1'b0);
        chk("R6", "read-after-write data slow", 32'(cpu_rdata), 32'h0000_A5C3);
        repeat (5) @(negedge clk);
        txn(1'b0, 24'h00_0009, 16'h0000, 1'b0);
        chk("R6", "preset word read", 32'(cpu_rdata), 32'h0000_9999);

        // R8: request held low through DONE, responder releases late
        gd = 2; sd = 2; rel = 3;
        repeat (5) @(negedge clk);
        txn(1'b1, 24'h00_000C, 16'h1357, 1'b1);
        @(negedge clk);
        chk("R8", "no request right after done", 32'(mem_req_n), 32'd1);
        @(negedge clk);
        chk("R8", "request held off while grant synced", 32'(mem_req_n), 32'd1);
        do @(negedge clk); while (!cpu_ack);
        cpu_greq_n = 1'b1;
        repeat (6) @(negedge clk);
        txn(1'b0, 24'h00_000C, 16'h0000, 1'b0);
        chk("R6", "held-off write landed", 32'(cpu_rdata), 32'h0000_1357);

        repeat (8) @(negedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: run did not complete, actual=hung expected=done");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule